// File: doc/BRIEF.md
# Remote-End Link Startup Sequencer

This block is the control state machine at the customer-premises end of a symmetric two-wire digital subscriber link. It sits between a 1 ms timebase, the receive-side detectors and convergence monitor, and the transmit path. From those inputs it chooses which startup line sequence the transmitter sends. Every training sequence is the scrambled all-ones two-level PAM signal at the agreed power cutback. The block also says when the framer must start a frame, and finally switches the link into data transmission. Signal processing is not part of it.

Every stage change is keyed to the far end. A wake-up from the far end is answered with a fixed-length response. A power-level frame exchange follows, then this end's own C training burst. This end then waits for the far end's S sequence and holds off for a fixed gap before adding its own S. It moves to the T sequence only once it has converged and hears the far end's T. Data mode starts when its own T frame has been sent. If the far-end S never appears, or convergence takes too long, the block parks in an exception state until a restart request.

Top module: `remote_startup_seq`

## Requirements
- R1: After reset, seq_sel is 0 (silence) and framer_start, data_mode and exception are all 0. The seq_sel codes are: 0 silence, 1 response A/B, 2 primed A/B (power frame), 3 C, 4 S, 5 T, 6 data.
- R2: From silence, far_wake_det moves seq_sel to 1 on the next clock. The response lasts exactly RESP_MS ticks, and then seq_sel becomes 2.
- R3: framer_start is a single-cycle pulse. It is high in the first cycle of code 2 and in the first cycle of code 5, and at no other time.
- R4: In code 2, frame_done moves seq_sel to 3 on the next clock. Code 3 lasts exactly C_MS ticks and is followed by silence (code 0).
- R5: During the post-C silence, far_s_det starts a silent gap of exactly GAP_MS ticks, after which seq_sel becomes 4.
- R6: If far_s_det has not been seen by the end of S_WAIT_MS ticks of post-C silence, exception rises, seq_sel is 0, and both stay that way until restart.
- R7: In code 4, the move to code 5 happens on the clock after converged and far_t_det are both high. Either flag alone has no effect.
- R8: If code 4 reaches S_MAX_MS ticks without the move to T, exception rises with seq_sel 0.
- R9: In code 5, frame_done moves seq_sel to 6 and raises data_mode. Data mode then holds until restart.
- R10: restart returns the block to silence with no flags on the next clock, from any state.
- R11: frame_done outside codes 2 and 5 has no effect on seq_sel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_ms | input | 1 | One-cycle pulse every millisecond |
| far_wake_det | input | 1 | Far-end wake-up sequence detected |
| far_s_det | input | 1 | Far-end S sequence detected |
| far_t_det | input | 1 | Far-end T sequence detected |
| converged | input | 1 | Local receiver training has converged |
| frame_done | input | 1 | Framer finished the current frame |
| restart | input | 1 | Abort and return to silence |
| seq_sel | output | 3 | Transmit sequence code |
| framer_start | output | 1 | Start pulse for the framer |
| data_mode | output | 1 | Link is in data transmission |
| exception | output | 1 | Startup failed, waiting for restart |

## Verification
The assertions check on every cycle that the framer pulse never lasts two cycles and that restart always clears the outputs. They also check that T is only entered with both convergence and far-end T present, that S is only entered from the gap, that data mode only follows T, and that exception is silent and sticky. The exact tick counts of each timed stage, and the boundary between a timely and a late far-end S or convergence, can only be shown by the bench's sweeps. Those sweeps move the event one tick at a time across each limit.

// File: rtl/remote_startup_seq.sv
module remote_startup_seq #(
  parameter int RESP_MS   = 200,
  parameter int C_MS      = 300,
  parameter int GAP_MS    = 1000,
  parameter int S_WAIT_MS = 3000,
  parameter int S_MAX_MS  = 30000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_ms,
  input  logic       far_wake_det,
  input  logic       far_s_det,
  input  logic       far_t_det,
  input  logic       converged,
  input  logic       frame_done,
  input  logic       restart,
  output logic [2:0] seq_sel,
  output logic       framer_start,
  output logic       data_mode,
  output logic       exception
);
  localparam int M1 = (RESP_MS > C_MS) ? RESP_MS : C_MS;
  localparam int M2 = (GAP_MS > S_WAIT_MS) ? GAP_MS : S_WAIT_MS;
  localparam int M3 = (M1 > M2) ? M1 : M2;
  localparam int MX = (M3 > S_MAX_MS) ? M3 : S_MAX_MS;
  localparam int TW = $clog2(MX + 1);

  typedef enum logic [3:0] {
    ST_IDLE, ST_RESP, ST_PRE, ST_CTRN, ST_WAITS,
    ST_GAP, ST_STRN, ST_TTRN, ST_DATA, ST_EXC
  } st_t;

  st_t st, nxt;
  logic [TW-1:0] cnt;

  wire at_lim_resp = tick_ms && (cnt == TW'(RESP_MS - 1));
  wire at_lim_c    = tick_ms && (cnt == TW'(C_MS - 1));
  wire at_lim_gap  = tick_ms && (cnt == TW'(GAP_MS - 1));
  wire at_lim_wait = tick_ms && (cnt == TW'(S_WAIT_MS - 1));
  wire at_lim_s    = tick_ms && (cnt == TW'(S_MAX_MS - 1));

  always_comb begin
    nxt = st;
    case (st)
      ST_IDLE:  if (far_wake_det) nxt = ST_RESP;
      ST_RESP:  if (at_lim_resp) nxt = ST_PRE;
      ST_PRE:   if (frame_done) nxt = ST_CTRN;
      ST_CTRN:  if (at_lim_c) nxt = ST_WAITS;
      ST_WAITS: if (far_s_det) nxt = ST_GAP;
                else if (at_lim_wait) nxt = ST_EXC;
      ST_GAP:   if (at_lim_gap) nxt = ST_STRN;
      ST_STRN:  if (converged && far_t_det) nxt = ST_TTRN;
                else if (at_lim_s) nxt = ST_EXC;
      ST_TTRN:  if (frame_done) nxt = ST_DATA;
      default:  nxt = st;
    endcase
    if (restart) nxt = ST_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st           <= ST_IDLE;
      cnt          <= '0;
      framer_start <= 1'b0;
    end else begin
      st           <= nxt;
      framer_start <= (nxt != st) && (nxt == ST_PRE || nxt == ST_TTRN);
      if (nxt != st)    cnt <= '0;
      else if (tick_ms) cnt <= cnt + TW'(1);
    end
  end

  always_comb begin
    case (st)
      ST_RESP:  seq_sel = 3'd1;
      ST_PRE:   seq_sel = 3'd2;
      ST_CTRN:  seq_sel = 3'd3;
      ST_STRN:  seq_sel = 3'd4;
      ST_TTRN:  seq_sel = 3'd5;
      ST_DATA:  seq_sel = 3'd6;
      default:  seq_sel = 3'd0;
    endcase
  end

  assign data_mode = (st == ST_DATA);
  assign exception = (st == ST_EXC);

  p_start_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    framer_start |=> !framer_start);
  p_restart_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (seq_sel == 3'd0 && !data_mode && !exception && !framer_start));
  p_t_needs_both_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_STRN && nxt == ST_TTRN) |-> (converged && far_t_det));
  p_s_after_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st != ST_STRN && nxt == ST_STRN) |-> (st == ST_GAP && tick_ms));
  p_data_after_t_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_mode) |-> $past(seq_sel) == 3'd5);
  p_exc_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (exception && !restart) |=> (exception && seq_sel == 3'd0));
endmodule

// File: tb/test_remote_startup_seq.sv
`timescale 1ns/1ps
module test_remote_startup_seq;
  localparam int RESP = 4, CM = 5, GAP = 3, SW = 6, SM = 7;

  logic clk = 0, rst_n = 0, tick_ms = 0, far_wake_det = 0, far_s_det = 0;
  logic far_t_det = 0, converged = 0, frame_done = 0, restart = 0;
  logic [2:0] seq_sel;
  logic framer_start, data_mode, exception;
  int n_run = 0, n_fail = 0;

  remote_startup_seq #(.RESP_MS(RESP), .C_MS(CM), .GAP_MS(GAP),
    .S_WAIT_MS(SW), .S_MAX_MS(SM)) i_remote_startup_seq (
    .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .far_wake_det(far_wake_det),
    .far_s_det(far_s_det), .far_t_det(far_t_det), .converged(converged),
    .frame_done(frame_done), .restart(restart), .seq_sel(seq_sel),
    .framer_start(framer_start), .data_mode(data_mode), .exception(exception));

  always #2.5 clk = ~clk;

  task automatic chk(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(); @(negedge clk); endtask
  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin tick_ms = 1; cyc(); tick_ms = 0; cyc(); end
  endtask
  task automatic pulse_fd(); frame_done = 1; cyc(); frame_done = 0; endtask

  task automatic do_restart();
    restart = 1; cyc(); restart = 0;
    chk("R10 seq", seq_sel, 0); chk("R10 exc", exception, 0); chk("R10 data", data_mode, 0);
  endtask

  task automatic to_wait_s(bit full);
    far_wake_det = 1; cyc(); far_wake_det = 0;
    if (full) chk("R2 resp", seq_sel, 1);
    ticks(RESP - 1);
    if (full) chk("R2 resp held", seq_sel, 1);
    tick_ms = 1; cyc(); tick_ms = 0;
    if (full) begin chk("R2 primed", seq_sel, 2); chk("R3 start", framer_start, 1); end
    cyc();
    if (full) chk("R3 start drop", framer_start, 0);
    pulse_fd();
    if (full) chk("R4 C", seq_sel, 3);
    ticks(CM - 1);
    if (full) chk("R4 C held", seq_sel, 3);
    ticks(1);
    if (full) chk("R4 silence", seq_sel, 0);
  endtask

  task automatic to_s();
    to_wait_s(0);
    far_s_det = 1; cyc(); far_s_det = 0;
    ticks(GAP);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) cyc();
    rst_n = 1; cyc();
    chk("R1 seq", seq_sel, 0); chk("R1 start", framer_start, 0);
    chk("R1 data", data_mode, 0); chk("R1 exc", exception, 0);
    ticks(3);
    chk("R2 no wake stays", seq_sel, 0);
    to_wait_s(1);
    pulse_fd();
    chk("R11 fd ignored", seq_sel, 0);
    far_s_det = 1; cyc(); far_s_det = 0;
    ticks(GAP - 1);
    chk("R5 gap silent", seq_sel, 0);
    ticks(1);
    chk("R5 S", seq_sel, 4);
    pulse_fd();
    chk("R11 fd in S", seq_sel, 4);
    converged = 1; ticks(2); cyc();
    chk("R7 conv only", seq_sel, 4);
    converged = 0; far_t_det = 1; cyc(); cyc();
    chk("R7 t only", seq_sel, 4);
    converged = 1; cyc(); converged = 0; far_t_det = 0;
    chk("R7 T", seq_sel, 5); chk("R3 T start", framer_start, 1);
    cyc(); chk("R3 T start drop", framer_start, 0);
    ticks(3); chk("R9 T waits", seq_sel, 5);
    pulse_fd();
    chk("R9 data seq", seq_sel, 6); chk("R9 data flag", data_mode, 1);
    ticks(SM + 2); pulse_fd();
    chk("R9 data held", data_mode, 1);
    do_restart();
    for (int k = 0; k <= SW; k++) begin
      to_wait_s(0);
      ticks(k);
      if (k >= SW) begin
        chk("R6 timeout exc", exception, 1); chk("R6 seq", seq_sel, 0);
        far_s_det = 1; ticks(GAP + 1); far_s_det = 0;
        chk("R6 sticky", exception, 1);
      end else begin
        far_s_det = 1; cyc(); far_s_det = 0;
        chk("R6 no exc", exception, 0);
        ticks(GAP); chk("R5 S reached", seq_sel, 4);
      end
      do_restart();
    end
    for (int k = 0; k <= SM; k++) begin
      to_s();
      ticks(k);
      converged = 1; far_t_det = 1; cyc(); converged = 0; far_t_det = 0;
      if (k >= SM) begin
        chk("R8 exc", exception, 1); chk("R8 seq", seq_sel, 0);
      end else begin
        chk("R8 T reached", seq_sel, 5); chk("R8 no exc", exception, 0);
      end
      do_restart();
    end
    far_wake_det = 1; cyc(); far_wake_det = 0; cyc();
    do_restart();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule